// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-Decimal Arithmetic and Status Update

This block is the arithmetic and logic datapath of a small 8-bit accumulator machine. From an operation code, a register value (accumulator or index), an 8-bit operand and the current status byte, it produces an 8-bit result, a flag telling the caller whether that result should be written back, and the next status byte. Add and subtract with carry work in plain binary or, when the decimal flag is set, in packed BCD. Digits outside 0..9 are handled the way the silicon of such machines handles them, so code that feeds such digits still gets the expected answers. The block also covers compare, the three bitwise logic operations, two forms of bit test, bit set and bit clear under a register mask, and shifts and rotates through the carry.

The result, write flag and next status are available combinationally. A second copy of all three is captured in registers on any rising clock edge where the load strobe is high. Instruction decode, memory access and cycle timing are left to the surrounding sequencer.

Top module: `alu8_core`

## Requirements
- R1: The operation code `op_sel` selects one of these: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 bit test, 7 bit test (immediate form), 8 set bits, 9 clear bits, 10 shift left, 11 shift right, 12 rotate left, 13 rotate right. `wr_out` is 1 for codes 0, 1, 3, 4, 5 and 8 through 13, and 0 otherwise. `res_out` is 0 whenever `wr_out` is 0. Codes 14 and 15 leave the status byte unchanged.
- R2: The status byte has N at bit 7, V at bit 6, D at bit 3, Z at bit 1 and C at bit 0. With D clear, add returns A+M+C. C is bit 8 of the 9-bit sum, V is signed overflow, and N and Z follow the 8-bit result.
- R3: With D set, add first corrects the low digit sum (A[3:0]+M[3:0]+C): when it is 10 or more, it is replaced by ((sum+6) mod 16)+16. It then adds the upper nibbles of A and M, each as a multiple of 16, and adds 0x60 when that total is 0xA0 or more. C is set when the final total is 0x100 or more. V is set when the signed sum of A&0xF0, M&0xF0 and the corrected low value lies outside -128..127. N and Z come from the result byte.
- R4: With D clear, subtract returns A-M-(1-C). C is set when that difference is not negative, V is signed overflow, and N and Z follow the result.
- R5: With D set, subtract takes the difference A-M-(1-C). It subtracts 0x60 when the difference is negative, and also subtracts 0x06 when the low-nibble difference A[3:0]-M[3:0]-(1-C) is negative. C is set when the uncorrected difference is not negative. V equals the binary subtract overflow, and N and Z follow the result byte.
- R6: Compare sets C when A is at least M (unsigned), N to bit 7 of A-M, and Z when A equals M. V is unchanged.
- R7: AND, OR and XOR return A op M and update only N and Z from the result.
- R8: Bit test sets N to M[7], V to M[6], and Z when A&M is zero. The immediate form updates Z the same way and leaves N and V unchanged.
- R9: Set bits returns M|A and clear bits returns M&~A. Both set Z from (A&M)==0 taken on the inputs, and leave N, V and C unchanged.
- R10: Shift left returns M<<1 with C=M[7]. Shift right returns M>>1 with C=M[0] and N cleared. Rotate left returns {M[6:0],C} with C=M[7]. Rotate right returns {C,M[7:1]} with C=M[0]. All four set N and Z from the result.
- R11: Status bits 5, 4, 3 and 2 pass through unchanged for every operation.
- R12: On a rising edge with `latch_en` high, `res_q`, `wr_q` and `stat_q` take the combinational outputs. With `latch_en` low they hold. A synchronous reset with `rst_n` low clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code |
| reg_val | input | 8 | Register operand A (accumulator or index) |
| opnd | input | 8 | Second operand M |
| stat_in | input | 8 | Current status byte |
| latch_en | input | 1 | Load strobe for the output registers |
| res_out | output | 8 | Combinational result |
| wr_out | output | 1 | Combinational result-write flag |
| stat_out | output | 8 | Combinational next status |
| res_q | output | 8 | Registered result |
| wr_q | output | 1 | Registered write flag |
| stat_q | output | 8 | Registered next status |

## Verification
The hardest behaviour to reach is decimal arithmetic on bytes that are not valid BCD. This includes the decimal-add overflow that comes from the intermediate signed sum, and the double correction on subtract when both the whole difference and the low digit go negative. Uniform random operands with D forced on in half of the vectors spend most of their time on non-BCD digits, so these paths are hit many times. Directed vectors add the exact carry edges (0x99+0x01, 0x00-0x01, 0x0F+0x0F) alongside the random traffic.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and status bit positions for the ALU.
// Assumes an 8-bit datapath; the operation code is 4 bits wide.
package alu8_pkg;
    localparam int DW    = 8;
    localparam int OPW   = 4;
    localparam int F_N   = 7;
    localparam int F_V   = 6;
    localparam int F_D   = 3;
    localparam int F_Z   = 1;
    localparam int F_C   = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_CMP  = 4'd2,  OP_AND  = 4'd3,
        OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_BIT  = 4'd6,  OP_BITI = 4'd7,
        OP_SETB = 4'd8,  OP_CLRB = 4'd9,  OP_SHL  = 4'd10, OP_SHR  = 4'd11,
        OP_ROL  = 4'd12, OP_ROR  = 4'd13, OP_R14  = 4'd14, OP_R15  = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
// Module: add/subtract with carry, binary or packed decimal.
// Assumes: cin is the status carry; for subtract the borrow is its inverse.
// Decimal results for non-BCD digits follow the nibble correction rules.
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic          sub,
    input  logic          dec,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          vout
);
    localparam int WW = DW + 2;

    logic [DW-1:0] m_x;
    logic [DW:0]   bin_sum;
    logic          bin_v;
    logic [4:0]    lo_add;
    logic [5:0]    lo_fix;
    logic [WW-1:0] s_add, s_add_fix;
    logic signed [WW-1:0] t_add;
    logic [5:0]    lo_sub;
    logic [WW-1:0] s_sub, s_sub_fix;

    // Binary sum; subtract adds the inverted operand
    always_comb begin
        m_x     = sub ? ~m : m;
        bin_sum = {1'b0, a} + {1'b0, m_x} + {{DW{1'b0}}, cin};
        bin_v   = (a[DW-1] == m_x[DW-1]) && (bin_sum[DW-1] != a[DW-1]);
    end

    // Decimal add with low-digit correction and signed intermediate for V
    always_comb begin
        lo_add    = {1'b0, a[3:0]} + {1'b0, m[3:0]} + {4'b0, cin};
        lo_fix    = (lo_add >= 5'd10) ? ({2'b0, 4'((lo_add + 5'd6) & 5'h0F)} + 6'h10)
                                      : {1'b0, lo_add};
        s_add     = {2'b0, a[7:4], 4'b0} + {2'b0, m[7:4], 4'b0} + {4'b0, lo_fix};
        t_add     = $signed({{2{a[7]}}, a[7:4], 4'b0}) + $signed({{2{m[7]}}, m[7:4], 4'b0})
                  + $signed({4'b0, lo_fix});
        s_add_fix = (s_add >= 10'h0A0) ? s_add + 10'h060 : s_add;
    end

    // Decimal subtract with whole and low-digit borrow corrections
    always_comb begin
        lo_sub    = {2'b0, a[3:0]} - {2'b0, m[3:0]} - {5'b0, ~cin};
        s_sub     = {2'b0, a} - {2'b0, m} - {{(WW-1){1'b0}}, ~cin};
        s_sub_fix = s_sub - (s_sub[WW-1] ? 10'h060 : 10'h000)
                          - (lo_sub[5]   ? 10'h006 : 10'h000);
    end

    // Select variant
    always_comb begin
        if (!dec) begin
            res  = bin_sum[DW-1:0];
            cout = bin_sum[DW];
            vout = bin_v;
        end else if (!sub) begin
            res  = s_add_fix[DW-1:0];
            cout = s_add_fix >= 10'h100;
            vout = (t_add < -10'sd128) || (t_add > 10'sd127);
        end else begin
            res  = s_sub_fix[DW-1:0];
            cout = ~s_sub[WW-1];
            vout = bin_v;
        end
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise operations, including masked set and clear of bits.
// Assumes op is one of the logic codes; returns zero for anything else.
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] m,
    output logic [DW-1:0] res
);
    // Bitwise result by operation
    always_comb begin
        unique case (op)
            OP_AND:  res = a & m;
            OP_OR:   res = a | m;
            OP_XOR:  res = a ^ m;
            OP_SETB: res = m | a;
            OP_CLRB: res = m & ~a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
// Module: one-place shifts and rotates through carry.
// Assumes op is a shift code; otherwise result is zero and carry passes.
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] m,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    // Shift or rotate and carry out
    always_comb begin
        unique case (op)
            OP_SHL:  begin res = {m[DW-2:0], 1'b0}; cout = m[DW-1]; end
            OP_SHR:  begin res = {1'b0, m[DW-1:1]}; cout = m[0];    end
            OP_ROL:  begin res = {m[DW-2:0], cin};  cout = m[DW-1]; end
            OP_ROR:  begin res = {cin, m[DW-1:1]};  cout = m[0];    end
            default: begin res = '0;                cout = cin;     end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
// Module: top of the ALU. Picks the unit result, builds the next status
// and holds a registered copy loaded by latch_en.
// Assumes: synchronous active-low reset; status bits 5..2 are never written.
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [7:0]    reg_val,
    input  logic [7:0]    opnd,
    input  logic [7:0]    stat_in,
    input  logic          latch_en,
    output logic [7:0]    res_out,
    output logic          wr_out,
    output logic [7:0]    stat_out,
    output logic [7:0]    res_q,
    output logic          wr_q,
    output logic [7:0]    stat_q
);
    alu_op_e       op;
    logic [DW-1:0] as_res, lg_res, sh_res, cmp_diff;
    logic          as_c, as_v, sh_c;

    assign op = alu_op_e'(op_sel);

    alu8_addsub u_as (
        .sub (op == OP_SUB), .dec (stat_in[F_D]), .a (reg_val), .m (opnd),
        .cin (stat_in[F_C]), .res (as_res), .cout (as_c), .vout (as_v)
    );

    alu8_logic u_lg (.op (op), .a (reg_val), .m (opnd), .res (lg_res));

    alu8_shift u_sh (.op (op), .m (opnd), .cin (stat_in[F_C]), .res (sh_res), .cout (sh_c));

    // Result select and next status
    always_comb begin
        cmp_diff = reg_val - opnd;
        res_out  = '0;
        wr_out   = 1'b0;
        stat_out = stat_in;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res_out = as_res; wr_out = 1'b1;
                stat_out[F_C] = as_c; stat_out[F_V] = as_v;
                stat_out[F_N] = as_res[DW-1]; stat_out[F_Z] = (as_res == '0);
            end
            OP_CMP: begin
                stat_out[F_C] = (reg_val >= opnd);
                stat_out[F_N] = cmp_diff[DW-1]; stat_out[F_Z] = (cmp_diff == '0);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_out = lg_res; wr_out = 1'b1;
                stat_out[F_N] = lg_res[DW-1]; stat_out[F_Z] = (lg_res == '0);
            end
            OP_BIT: begin
                stat_out[F_N] = opnd[7]; stat_out[F_V] = opnd[6];
                stat_out[F_Z] = ((reg_val & opnd) == '0);
            end
            OP_BITI: stat_out[F_Z] = ((reg_val & opnd) == '0);
            OP_SETB, OP_CLRB: begin
                res_out = lg_res; wr_out = 1'b1;
                stat_out[F_Z] = ((reg_val & opnd) == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_out = sh_res; wr_out = 1'b1; stat_out[F_C] = sh_c;
                stat_out[F_N] = sh_res[DW-1]; stat_out[F_Z] = (sh_res == '0);
            end
            default: ;
        endcase
    end

    // Registered copy, loaded on strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0; wr_q <= 1'b0; stat_q <= '0;
        end else if (latch_en) begin
            res_q <= res_out; wr_q <= wr_out; stat_q <= stat_out;
        end
    end
endmodule

// File: rtl/alu8_chk.sv
// Module: property checker for alu8_core, attached by bind below.
// Assumes clk/rst_n as in the core; observes ports only.
module alu8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic [7:0] reg_val,
    input logic [7:0] opnd,
    input logic [7:0] stat_in,
    input logic       latch_en,
    input logic [7:0] res_out,
    input logic       wr_out,
    input logic [7:0] stat_out,
    input logic [7:0] res_q,
    input logic       wr_q,
    input logic [7:0] stat_q
);
    a_r11_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat_out[5:2] == stat_in[5:2]);
    a_r1_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |-> res_out == 8'h00);
    a_r6_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'd2 |-> (!wr_out && stat_out[0] == (reg_val >= opnd)));
    a_r10_shr_neg: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'd11 |-> !stat_out[7]);
    a_r8_imm_nv: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'd7 |-> stat_out[7:6] == stat_in[7:6]);
    a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (stat_q == $past(stat_out) && res_q == $past(res_out) && wr_q == $past(wr_out)));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> ($stable(stat_q) && $stable(res_q) && $stable(wr_q)));
endmodule

bind alu8_core alu8_chk u_chk (
    .clk (clk), .rst_n (rst_n), .op_sel (op_sel), .reg_val (reg_val), .opnd (opnd),
    .stat_in (stat_in), .latch_en (latch_en), .res_out (res_out), .wr_out (wr_out),
    .stat_out (stat_out), .res_q (res_q), .wr_q (wr_q), .stat_q (stat_q)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] reg_val = '0, opnd = '0, stat_in = '0;
    logic       latch_en = 1'b0;
    logic [7:0] res_out, stat_out, res_q, stat_q;
    logic       wr_out, wr_q;
    int         n_chk = 0, n_fail = 0;
    logic [16:0] held = '0;

    always #4 clk = ~clk;

    alu8_core u0 (
        .clk (clk), .rst_n (rst_n), .op_sel (op_sel), .reg_val (reg_val), .opnd (opnd),
        .stat_in (stat_in), .latch_en (latch_en), .res_out (res_out), .wr_out (wr_out),
        .stat_out (stat_out), .res_q (res_q), .wr_q (wr_q), .stat_q (stat_q)
    );

    function automatic int sx(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic string tag_of(int op, int p);
        case (op)
            0: return ((p >> 3) & 1) ? "R3" : "R2";
            1: return ((p >> 3) & 1) ? "R5" : "R4";
            2: return "R6";
            3, 4, 5: return "R7";
            6, 7: return "R8";
            8, 9: return "R9";
            10, 11, 12, 13: return "R10";
            default: return "R1";
        endcase
    endfunction

    // Reference model: returns {wr, result, status}
    function automatic logic [16:0] model(int op, int a, int m, int p);
        int c, d, s, l, t, r, st, wr, v, cy;
        c = p & 1; d = (p >> 3) & 1; st = p; r = 0; wr = 0;
        case (op)
            0: begin
                if (d == 0) begin
                    s = a + m + c; r = s & 255; cy = (s > 255);
                    v = ((~(a ^ m)) & (a ^ r) & 128) != 0;
                end else begin
                    l = (a & 15) + (m & 15) + c;
                    if (l >= 10) l = ((l + 6) & 15) + 16;
                    s = (a & 240) + (m & 240) + l;
                    t = sx(a & 240) + sx(m & 240) + l;
                    v = (t < -128) || (t > 127);
                    if (s >= 160) s = s + 96;
                    cy = (s >= 256); r = s & 255;
                end
                wr = 1; st = (st & 8'h3C) | (cy) | (v << 6);
                st = st | ((r & 128)) | ((r == 0) << 1);
            end
            1: begin
                s = a - m - (1 - c); cy = (s >= 0);
                v = ((a ^ m) & (a ^ (s & 255)) & 128) != 0;
                if (d == 0) r = s & 255;
                else begin
                    l = (a & 15) - (m & 15) - (1 - c);
                    if (s < 0) s = s - 96;
                    if (l < 0) s = s - 6;
                    r = s & 255;
                end
                wr = 1; st = (st & 8'h3C) | cy | (v << 6) | (r & 128) | ((r == 0) << 1);
            end
            2: begin
                s = (a - m) & 255;
                st = (st & 8'h7C) | (a >= m) | (s & 128) | ((s == 0) << 1);
            end
            3, 4, 5: begin
                r = (op == 3) ? (a & m) : (op == 4) ? (a | m) : (a ^ m);
                wr = 1; st = (st & 8'h7D) | (r & 128) | ((r == 0) << 1);
            end
            6: st = (st & 8'h3D) | (m & 8'hC0) | (((a & m) == 0) << 1);
            7: st = (st & 8'hFD) | (((a & m) == 0) << 1);
            8, 9: begin
                r = (op == 8) ? (m | a) : (m & ~a & 255);
                wr = 1; st = (st & 8'hFD) | (((a & m) == 0) << 1);
            end
            10, 11, 12, 13: begin
                case (op)
                    10: begin r = (m << 1) & 255; cy = m >> 7; end
                    11: begin r = m >> 1; cy = m & 1; end
                    12: begin r = ((m << 1) & 255) | c; cy = m >> 7; end
                    default: begin r = (c << 7) | (m >> 1); cy = m & 1; end
                endcase
                wr = 1; st = (st & 8'h7C) | cy | (r & 128) | ((r == 0) << 1);
            end
            default: ;
        endcase
        return {wr[0], r[7:0], st[7:0]};
    endfunction

    task automatic check(string tag, string what, logic [16:0] act, logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual wr=%0b res=%02h st=%02h expected wr=%0b res=%02h st=%02h",
                     tag, what, act[16], act[15:8], act[7:0], exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    // Drive one vector at the falling edge, check combinational then registered
    task automatic apply(int op, int a, int m, int p, bit en);
        logic [16:0] e;
        @(negedge clk);
        op_sel = op[3:0]; reg_val = a[7:0]; opnd = m[7:0]; stat_in = p[7:0]; latch_en = en;
        e = model(op, a, m, p);
        #1 check(tag_of(op, p), "comb", {wr_out, res_out, stat_out}, e);
        if (e[5:2] !== p[5:2]) $display("bench model error");
        @(posedge clk); #1;
        if (en) held = e;
        check("R12", en ? "load" : "hold", {wr_q, res_q, stat_q}, held);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        repeat (3) @(posedge clk);
        #1 check("R12", "reset", {wr_q, res_q, stat_q}, 17'h0);
        @(negedge clk); rst_n = 1'b1;
        // Directed corner cases
        apply(0, 8'h99, 8'h01, 8'h08, 1);   // R3: decimal carry to 00
        apply(0, 8'h0F, 8'h0F, 8'h08, 1);   // R3: non-BCD digits
        apply(0, 8'h7F, 8'h01, 8'h00, 1);   // R2: signed overflow
        apply(0, 8'hFF, 8'h00, 8'h01, 1);   // R2: carry out, zero
        apply(1, 8'h00, 8'h01, 8'h09, 1);   // R5: decimal borrow to 99
        apply(1, 8'h80, 8'h01, 8'h01, 1);   // R4: overflow
        apply(2, 8'h42, 8'h42, 8'h00, 0);   // R6: equal, hold check of R12
        apply(7, 8'h0F, 8'hF0, 8'hC0, 1);   // R8: immediate keeps N,V
        apply(9, 8'h0F, 8'hFF, 8'h00, 1);   // R9: clear bits
        apply(11, 0, 8'h81, 8'h80, 1);      // R10: right shift clears N
        apply(13, 0, 8'h01, 8'h01, 1);      // R10: rotate right with carry in
        apply(14, 8'h55, 8'hAA, 8'hFF, 1);  // R1 and R11: reserved code
        apply(15, 8'h01, 8'h02, 8'h3C, 0);  // R1: reserved code, hold
        // Random traffic; decimal flag on for about half of add/subtract vectors
        for (int i = 0; i < 4000; i++) begin
            int op, a, m, p;
            op = $urandom_range(0, 15);
            a  = $urandom_range(0, 255);
            m  = $urandom_range(0, 255);
            p  = $urandom_range(0, 255);
            apply(op, a, m, p, $urandom_range(0, 3) != 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule